// File: doc/BRIEF.md
# Queue-Threshold Flow Control Generator

This block watches the occupancy of each output queue of a shared-buffer Ethernet switch and decides, port by port, whether the link partner must be slowed down. Two 8-bit watermarks are applied to every queue's in-use buffer count. A high watermark marks congestion and a low watermark marks relief. The band between them gives hysteresis.

On a full-duplex port, congestion makes the block ask the MAC for one PAUSE frame with the largest pause value. When the queue later drains to the low watermark, it asks for one PAUSE frame with a zero value so the partner resumes. A pending request stays up until the MAC grants it with a one-cycle pulse. On a half-duplex port, the block asks for a jam pattern when the queue is congested and a frame is arriving, which forces a collision. When no buffer is free and back pressure cannot hold the sender, the arriving frame is flagged for dropping. Frame assembly, CRC and MAC timing belong to the MAC.

Top module: `qfc_ctrl`

## Requirements
- R1: On a full-duplex port with the pause enable set, a queue count at or above the high watermark raises `pause_req` on the next clock edge, with a pause value of 16'hFFFF, provided the port is not already paused.
- R2: Only one 16'hFFFF request is raised per congestion episode. While the count stays at or above the high watermark after the grant, no further request appears.
- R3: A paused port whose count falls to or below the low watermark raises `pause_req` with a pause value of 16'h0000. A port that was never paused raises no such request.
- R4: A raised request and its pause value stay unchanged until `pause_grant` is high for a cycle. After that cycle the request is low.
- R5: `thresh_cfg[7:0]` holds the high watermark and `thresh_cfg[15:8]` holds the low watermark. Counts strictly between the two start no request.
- R6: With `fd_pause_en` low, no 16'hFFFF request is started.
- R7: `jam_req` goes high on the next edge only when the port is half duplex, `bp_en` is high, the count is at or above the high watermark and `crs` is high. In every other case it stays low.
- R8: `drop_req` goes high on the next edge when `crs` and `no_free` are both high, unless the port is half duplex with `bp_en` high.
- R9: While `rst_n` is low and for two edges after it rises, all requests are low, and the paused state is cleared. A port paused before a reset therefore raises no zero-value request after it.
- R10: Ports are independent. Activity on one port starts no request on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_pause_en | input | 1 | Enables full-duplex PAUSE generation |
| bp_en | input | 1 | Enables half-duplex jamming |
| thresh_cfg | input | 16 | [7:0] high watermark, [15:8] low watermark |
| q_count | input | NPORTS*CNT_W | In-use buffer count per output queue, port p at [p*CNT_W +: CNT_W] |
| full_dup | input | NPORTS | 1 = port in full duplex |
| crs | input | NPORTS | Incoming frame sensed on the port |
| no_free | input | 1 | No free buffer left in the shared memory |
| pause_grant | input | NPORTS | One-cycle acknowledge of a pause request |
| pause_req | output | NPORTS | PAUSE frame wanted on the port |
| pause_time | output | NPORTS*16 | Pause value for the request, port p at [p*16 +: 16] |
| jam_req | output | NPORTS | Send jam pattern to force a collision |
| drop_req | output | NPORTS | Drop the frame now arriving |

## Verification
On every cycle, the assertions check that a request and its value stay still until granted and that a grant retires the request. They also check that the pause value is only ever all ones or zero, and that jam and drop never appear without carrier. Jam never appears in full duplex or with back pressure off, and no maximum-value request starts while the pause enable is low. Other behaviours depend on history, and only the directed scenarios can show them. These are the single request per congestion episode, the hysteresis band between the watermarks, the absence of a zero-value request without an earlier pause, and the paused state lost across reset.

// File: rtl/qfc_pkg.sv
package qfc_pkg;
  localparam int unsigned PAUSE_W = 16;
  localparam int unsigned TH_W    = 8;
  localparam logic [PAUSE_W-1:0] PAUSE_MAX  = '1;
  localparam logic [PAUSE_W-1:0] PAUSE_NONE = '0;

  typedef struct packed {
    logic at_high;  // count >= high watermark
    logic at_low;   // count <= low watermark
  } qlevel_t;
endpackage

// File: rtl/qfc_rst_sync.sv
module qfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/qfc_level_cmp.sv
module qfc_level_cmp
  import qfc_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic [CNT_W-1:0] count,
  input  logic [TH_W-1:0]  high_th,
  input  logic [TH_W-1:0]  low_th,
  output qlevel_t          level
);
  localparam int unsigned EXT_W = CNT_W - TH_W;

  logic [CNT_W-1:0] high_ext, low_ext;

  assign high_ext = {{EXT_W{1'b0}}, high_th};
  assign low_ext  = {{EXT_W{1'b0}}, low_th};

  always_comb begin
    level.at_high = (count >= high_ext);
    level.at_low  = (count <= low_ext);
  end
endmodule

// File: rtl/qfc_port.sv
module qfc_port
  import qfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fd_pause_en,
  input  logic               bp_en,
  input  logic               full_dup,
  input  logic               crs,
  input  logic               no_free,
  input  qlevel_t            level,
  input  logic               grant,
  output logic               pause_req,
  output logic [PAUSE_W-1:0] pause_time,
  output logic               jam_req,
  output logic               drop_req
);
  logic               pend_q, pend_d;
  logic               paused_q, paused_d;
  logic [PAUSE_W-1:0] time_q, time_d;
  logic               upd_en;
  logic               jam_d, drop_d;
  logic               start_xoff, start_xon;

  // next-state logic for the pause handshake and paused flag
  always_comb begin
    start_xoff = !pend_q && !paused_q && level.at_high && fd_pause_en && full_dup;
    start_xon  = !pend_q && paused_q && level.at_low;
    pend_d     = pend_q;
    paused_d   = paused_q;
    time_d     = time_q;
    if (pend_q && grant) begin
      pend_d = 1'b0;
    end
    if (start_xoff) begin
      pend_d   = 1'b1;
      paused_d = 1'b1;
      time_d   = PAUSE_MAX;
    end else if (start_xon) begin
      pend_d   = 1'b1;
      paused_d = 1'b0;
      time_d   = PAUSE_NONE;
    end
    upd_en = start_xoff || start_xon || (pend_q && grant);
  end

  // jam and drop decisions for the frame now arriving
  always_comb begin
    jam_d  = bp_en && !full_dup && level.at_high && crs;
    drop_d = crs && no_free && !(bp_en && !full_dup);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      paused_q <= 1'b0;
      time_q   <= PAUSE_NONE;
    end else if (upd_en) begin
      pend_q   <= pend_d;
      paused_q <= paused_d;
      time_q   <= time_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jam_req  <= 1'b0;
      drop_req <= 1'b0;
    end else begin
      jam_req  <= jam_d;
      drop_req <= drop_d;
    end
  end

  assign pause_req  = pend_q;
  assign pause_time = time_q;
endmodule

// File: rtl/qfc_ctrl.sv
module qfc_ctrl
  import qfc_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned CNT_W  = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fd_pause_en,
  input  logic                      bp_en,
  input  logic [15:0]               thresh_cfg,
  input  logic [NPORTS*CNT_W-1:0]   q_count,
  input  logic [NPORTS-1:0]         full_dup,
  input  logic [NPORTS-1:0]         crs,
  input  logic                      no_free,
  input  logic [NPORTS-1:0]         pause_grant,
  output logic [NPORTS-1:0]         pause_req,
  output logic [NPORTS*PAUSE_W-1:0] pause_time,
  output logic [NPORTS-1:0]         jam_req,
  output logic [NPORTS-1:0]         drop_req
);
  logic            rst_core_n;
  logic [TH_W-1:0] high_th, low_th;

  assign high_th = thresh_cfg[7:0];
  assign low_th  = thresh_cfg[15:8];

  qfc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    qlevel_t lvl;

    qfc_level_cmp #(.CNT_W(CNT_W)) u_cmp (
      .count   (q_count[p*CNT_W +: CNT_W]),
      .high_th (high_th),
      .low_th  (low_th),
      .level   (lvl)
    );

    qfc_port u_port (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .fd_pause_en (fd_pause_en),
      .bp_en       (bp_en),
      .full_dup    (full_dup[p]),
      .crs         (crs[p]),
      .no_free     (no_free),
      .level       (lvl),
      .grant       (pause_grant[p]),
      .pause_req   (pause_req[p]),
      .pause_time  (pause_time[p*PAUSE_W +: PAUSE_W]),
      .jam_req     (jam_req[p]),
      .drop_req    (drop_req[p])
    );
  end
endmodule

// File: rtl/qfc_ctrl_chk.sv
module qfc_ctrl_chk #(
  parameter int unsigned NPORTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fd_pause_en,
  input logic                bp_en,
  input logic [NPORTS-1:0]   full_dup,
  input logic [NPORTS-1:0]   crs,
  input logic [NPORTS-1:0]   pause_grant,
  input logic [NPORTS-1:0]   pause_req,
  input logic [NPORTS*16-1:0] pause_time,
  input logic [NPORTS-1:0]   jam_req,
  input logic [NPORTS-1:0]   drop_req
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req[i] && !pause_grant[i] |=> pause_req[i] && $stable(pause_time[i*16 +: 16]));

    p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req[i] && pause_grant[i] |=> !pause_req[i]);

    p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req[i] |-> (pause_time[i*16 +: 16] == 16'hFFFF) || (pause_time[i*16 +: 16] == 16'h0000));

    p_no_xoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fd_pause_en && !pause_req[i] |=> !pause_req[i] || (pause_time[i*16 +: 16] == 16'h0000));

    p_jam_fd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full_dup[i] |=> !jam_req[i]);

    p_jam_crs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !crs[i] |=> !jam_req[i]);

    p_jam_bp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_en |=> !jam_req[i]);

    p_drop_crs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !crs[i] |=> !drop_req[i]);
  end
endmodule

bind qfc_ctrl qfc_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fd_pause_en (fd_pause_en),
  .bp_en       (bp_en),
  .full_dup    (full_dup),
  .crs         (crs),
  .pause_grant (pause_grant),
  .pause_req   (pause_req),
  .pause_time  (pause_time),
  .jam_req     (jam_req),
  .drop_req    (drop_req)
);

// File: tb/qfc_ctrl_test.sv
`timescale 1ns/1ps
module qfc_ctrl_test;
  localparam int NP = 4;
  localparam int CW = 11;

  logic              clk;
  logic              rst_n;
  logic              fd_pause_en;
  logic              bp_en;
  logic [15:0]       thresh_cfg;
  logic [NP*CW-1:0]  q_count;
  logic [NP-1:0]     full_dup;
  logic [NP-1:0]     crs;
  logic              no_free;
  logic [NP-1:0]     pause_grant;
  logic [NP-1:0]     pause_req;
  logic [NP*16-1:0]  pause_time;
  logic [NP-1:0]     jam_req;
  logic [NP-1:0]     drop_req;

  int n_chk = 0;
  int n_err = 0;

  qfc_ctrl #(.NPORTS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .fd_pause_en(fd_pause_en), .bp_en(bp_en),
    .thresh_cfg(thresh_cfg), .q_count(q_count), .full_dup(full_dup), .crs(crs),
    .no_free(no_free), .pause_grant(pause_grant), .pause_req(pause_req),
    .pause_time(pause_time), .jam_req(jam_req), .drop_req(drop_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_cnt(input int p, input int v);
    q_count[p*CW +: CW] = v[CW-1:0];
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ptime(input int p);
    return int'(pause_time[p*16 +: 16]);
  endfunction

  task automatic grant(input int p);
    pause_grant[p] = 1'b1;
    step();
    pause_grant[p] = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    chk("R9 reset pause_req", int'(pause_req), 0);
    chk("R9 reset jam_req", int'(jam_req), 0);
    chk("R9 reset drop_req", int'(drop_req), 0);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_xoff_xon();
    thresh_cfg = 16'h3074;
    set_cnt(0, 'h73); step();
    chk("R5 below high no request", int'(pause_req[0]), 0);
    set_cnt(0, 'h74); step();
    chk("R1 xoff request", int'(pause_req[0]), 1);
    chk("R1 xoff value", ptime(0), 'hFFFF);
    chk("R10 other port quiet", int'(pause_req[3:1]), 0);
    step(3);
    chk("R4 held without grant", int'(pause_req[0]), 1);
    chk("R4 value held", ptime(0), 'hFFFF);
    grant(0);
    chk("R4 cleared after grant", int'(pause_req[0]), 0);
    set_cnt(0, 'h90); step(4);
    chk("R2 single xoff per episode", int'(pause_req[0]), 0);
    set_cnt(0, 'h31); step(2);
    chk("R5 hysteresis band", int'(pause_req[0]), 0);
    set_cnt(0, 'h30); step();
    chk("R3 xon request", int'(pause_req[0]), 1);
    chk("R3 xon value", ptime(0), 0);
    grant(0);
    set_cnt(0, 'h05); step(3);
    chk("R3 no xon without prior xoff", int'(pause_req[0]), 0);
  endtask

  task automatic t_small_buf();
    thresh_cfg = 16'h182E;
    set_cnt(0, 'h2D); step();
    chk("R5 1MB below high", int'(pause_req[0]), 0);
    set_cnt(0, 'h2E); step();
    chk("R5 1MB xoff", ptime(0) | (int'(pause_req[0]) << 16), 'h1FFFF);
    grant(0);
    set_cnt(0, 'h19); step();
    chk("R5 1MB above low", int'(pause_req[0]), 0);
    set_cnt(0, 'h18); step();
    chk("R3 1MB xon", ptime(0) | (int'(pause_req[0]) << 16), 'h10000);
    grant(0);
    set_cnt(0, 0);
    thresh_cfg = 16'h3074;
  endtask

  task automatic t_fd_off();
    fd_pause_en = 1'b0;
    set_cnt(0, 'h100); step(3);
    chk("R6 pause disabled", int'(pause_req[0]), 0);
    set_cnt(0, 0); step();
    fd_pause_en = 1'b1;
  endtask

  task automatic t_jam();
    full_dup[1] = 1'b0;
    set_cnt(1, 'h74); crs[1] = 1'b1; step();
    chk("R7 jam half duplex", int'(jam_req[1]), 1);
    chk("R7 no pause in half duplex", int'(pause_req[1]), 0);
    crs[1] = 1'b0; step();
    chk("R7 no jam without carrier", int'(jam_req[1]), 0);
    crs[1] = 1'b1; set_cnt(1, 'h73); step();
    chk("R7 no jam below high", int'(jam_req[1]), 0);
    set_cnt(1, 'h80); bp_en = 1'b0; step();
    chk("R7 no jam with bp off", int'(jam_req[1]), 0);
    bp_en = 1'b1; fd_pause_en = 1'b0; full_dup[1] = 1'b1; step();
    chk("R7 no jam in full duplex", int'(jam_req[1]), 0);
    crs[1] = 1'b0; set_cnt(1, 0); fd_pause_en = 1'b1; step();
  endtask

  task automatic t_drop();
    full_dup[2] = 1'b0; bp_en = 1'b0; no_free = 1'b1; crs[2] = 1'b1; step();
    chk("R8 drop bp off", int'(drop_req[2]), 1);
    bp_en = 1'b1; step();
    chk("R8 no drop when back pressure holds", int'(drop_req[2]), 0);
    full_dup[2] = 1'b1; step();
    chk("R8 drop full duplex", int'(drop_req[2]), 1);
    no_free = 1'b0; step();
    chk("R8 no drop with free buffers", int'(drop_req[2]), 0);
    no_free = 1'b1; crs[2] = 1'b0; step();
    chk("R8 no drop without carrier", int'(drop_req[2]), 0);
    no_free = 1'b0; step();
  endtask

  task automatic t_reset_clears();
    set_cnt(0, 'h80); step();
    chk("R1 xoff before reset", int'(pause_req[0]), 1);
    grant(0);
    rst_n = 1'b0;
    set_cnt(0, 'h10);
    step(2);
    chk("R9 requests low in reset", int'(pause_req), 0);
    rst_n = 1'b1;
    step(5);
    chk("R9 paused state cleared", int'(pause_req[0]), 0);
  endtask

  initial begin
    rst_n = 1'b0; fd_pause_en = 1'b1; bp_en = 1'b1; thresh_cfg = 16'h3074;
    q_count = '0; full_dup = '1; crs = '0; no_free = 1'b0; pause_grant = '0;
    t_reset();
    t_xoff_xon();
    t_small_buf();
    t_fd_off();
    t_jam();
    t_drop();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule